// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a simple single-bus processor. Every clock it emits one horizontal control word, with one bit per datapath gate or strobe. The word is read from an internal control store at the address held in a microprogram counter. Besides the control bits, each stored word carries a two-bit sequencing code, a condition-select bit and a branch target. Together these decide where the counter goes next: the following word, a branch target (always, or only when the selected flag is set), or the first word of the microroutine for the opcode now in the instruction register.

The shared fetch routine sits at address 0 and ends in a dispatch. Each machine instruction's routine finishes with a word whose done bit is set, and that word returns the counter to the fetch routine. A word that waits for memory keeps the counter, and therefore the control word, frozen until the memory reports completion. The contents of the control store are computed at elaboration time, so nothing is loaded from outside.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low and after its release, `micro_addr` is 0 and `ctrl_word` is 16'h003F. Bit order of `ctrl_word`: 0 pc_drive, 1 mar_load, 2 mem_read, 3 sel_const, 4 alu_add, 5 z_load, 6 z_drive, 7 ra_drive, 8 ra_load, 9 rc_drive, 10 wait_mem, 11 mdr_drive, 12 ir_load, 13 y_load, 14 pc_load, 15 done.
- R2: The fetch routine runs 0 → 1 → 2. Word 1 is 16'h6440 and waits for memory. Word 2 is 16'h1800 and dispatches.
- R3: A dispatch word loads the counter with the start address of `ir_opcode`: opcode 0 → 3, 1 → 8, 2 → 12, 3 → 16.
- R4: A word with sequencing code 00 (and neither hold nor done) moves the counter to the next address.
- R5: Code 01 is a conditional branch. The condition-select bit picks `flag_n` (0) or `flag_z` (1). If the selected flag is 1 the counter takes the target, otherwise it takes the next address. Word 8 tests N with target 10. Word 12 tests Z with target 14.
- R6: Code 10 always loads the target. Word 16 jumps to 18, so word 17 is never reached.
- R7: When `wait_mem` is set and `mem_done` is 0, the counter and `ctrl_word` hold. This takes priority over done and the sequencing code. `mem_done` has no effect on a word without `wait_mem`.
- R8: A word with `done` set returns the counter to 0 on the next clock, whatever its sequencing code. `end_flag` equals bit 15 of `ctrl_word`.
- R9: The add-from-memory routine is words 3..6: 16'h0206, 16'h2480 (waits), 16'h0830, 16'h8140 (done). The whole instruction, with fetch, takes 7 words.
- R10: The flag that is not selected has no effect. The Z-testing routine with N=1 and Z=0 falls through to word 13. Words 9, 11, 13, 15 and 18 carry done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_opcode | input | 2 | Opcode field of the instruction register |
| flag_n | input | 1 | Negative condition flag |
| flag_z | input | 1 | Zero condition flag |
| mem_done | input | 1 | Memory operation complete |
| ctrl_word | output | 16 | Horizontal control word of the current microinstruction |
| end_flag | output | 1 | Last microinstruction of the instruction |
| micro_addr | output | 5 | Current microprogram counter |

## Verification
The bench stalls the memory wait on both waiting words for several cycles. A sequencer that lets hold lose to the done bit or to sequencing would skip ahead with a half-finished read. It also drives `mem_done` low on a word that does not wait, to catch a design that stalls on any word. Both branch flavours are run taken and not taken, with the unselected flag set the opposite way, so a condition mux wired to the wrong flag or with inverted polarity lands on the wrong address. The jump routine exposes a branch that falls through to its dead word. Back-to-back instructions check that done lands exactly on address 0 and not one past it.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int CTRL_W = 16;
  localparam int UA_W   = 5;
  localparam int OP_W   = 2;
  localparam int DEPTH  = 1 << UA_W;

  // control bit positions
  localparam int B_PC_DRIVE  = 0;
  localparam int B_MAR_LOAD  = 1;
  localparam int B_MEM_READ  = 2;
  localparam int B_SEL_CONST = 3;
  localparam int B_ALU_ADD   = 4;
  localparam int B_Z_LOAD    = 5;
  localparam int B_Z_DRIVE   = 6;
  localparam int B_RA_DRIVE  = 7;
  localparam int B_RA_LOAD   = 8;
  localparam int B_RC_DRIVE  = 9;
  localparam int B_WAIT_MEM  = 10;
  localparam int B_MDR_DRIVE = 11;
  localparam int B_IR_LOAD   = 12;
  localparam int B_Y_LOAD    = 13;
  localparam int B_PC_LOAD   = 14;
  localparam int B_DONE      = 15;

  typedef enum logic [1:0] {
    SQ_NEXT     = 2'b00,
    SQ_BRCOND   = 2'b01,
    SQ_JUMP     = 2'b10,
    SQ_DISPATCH = 2'b11
  } seq_e;

  typedef struct packed {
    seq_e              seq;
    logic              test_z;
    logic [UA_W-1:0]   target;
    logic [CTRL_W-1:0] ctrl;
  } uinstr_t;

  function automatic logic [CTRL_W-1:0] sig(input int pos);
    return CTRL_W'(1) << pos;
  endfunction

  function automatic uinstr_t mk(input seq_e s, input logic tz, input int tgt,
                                 input logic [CTRL_W-1:0] c);
    uinstr_t w;
    w.seq    = s;
    w.test_z = tz;
    w.target = UA_W'(tgt);
    w.ctrl   = c;
    return w;
  endfunction

  // start address of each machine instruction's microroutine
  function automatic logic [UA_W-1:0] start_of(input logic [OP_W-1:0] op);
    case (op)
      2'd0:    return UA_W'(3);
      2'd1:    return UA_W'(8);
      2'd2:    return UA_W'(12);
      default: return UA_W'(16);
    endcase
  endfunction

  function automatic logic [UA_W-1:0] succ(input logic [UA_W-1:0] a);
    return a + UA_W'(1);
  endfunction

  // control store contents
  function automatic uinstr_t program_word(input int a);
    case (a)
      0:  return mk(SQ_NEXT, 1'b0, 0, sig(B_PC_DRIVE) | sig(B_MAR_LOAD) | sig(B_MEM_READ) |
                                      sig(B_SEL_CONST) | sig(B_ALU_ADD) | sig(B_Z_LOAD));
      1:  return mk(SQ_NEXT, 1'b0, 0, sig(B_Z_DRIVE) | sig(B_PC_LOAD) | sig(B_Y_LOAD) |
                                      sig(B_WAIT_MEM));
      2:  return mk(SQ_DISPATCH, 1'b0, 0, sig(B_MDR_DRIVE) | sig(B_IR_LOAD));
      3:  return mk(SQ_NEXT, 1'b0, 0, sig(B_RC_DRIVE) | sig(B_MAR_LOAD) | sig(B_MEM_READ));
      4:  return mk(SQ_NEXT, 1'b0, 0, sig(B_RA_DRIVE) | sig(B_Y_LOAD) | sig(B_WAIT_MEM));
      5:  return mk(SQ_NEXT, 1'b0, 0, sig(B_MDR_DRIVE) | sig(B_ALU_ADD) | sig(B_Z_LOAD));
      6:  return mk(SQ_NEXT, 1'b0, 0, sig(B_Z_DRIVE) | sig(B_RA_LOAD) | sig(B_DONE));
      8:  return mk(SQ_BRCOND, 1'b0, 10, '0);
      10: return mk(SQ_NEXT, 1'b0, 0, sig(B_PC_DRIVE) | sig(B_Y_LOAD));
      11: return mk(SQ_NEXT, 1'b0, 0, sig(B_Z_DRIVE) | sig(B_PC_LOAD) | sig(B_DONE));
      12: return mk(SQ_BRCOND, 1'b1, 14, '0);
      14: return mk(SQ_NEXT, 1'b0, 0, sig(B_PC_DRIVE) | sig(B_Y_LOAD));
      15: return mk(SQ_NEXT, 1'b0, 0, sig(B_Z_DRIVE) | sig(B_PC_LOAD) | sig(B_DONE));
      16: return mk(SQ_JUMP, 1'b0, 18, '0);
      17: return mk(SQ_NEXT, 1'b0, 0, sig(B_RA_LOAD) | sig(B_DONE));
      18: return mk(SQ_NEXT, 1'b0, 0, sig(B_RA_DRIVE) | sig(B_PC_LOAD) | sig(B_DONE));
      default: return mk(SQ_NEXT, 1'b0, 0, sig(B_DONE));
    endcase
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW = UA_W,
  localparam int N = 1 << AW
) (
  input  logic [AW-1:0] addr,
  output uinstr_t       word
);

  uinstr_t mem [N];

  for (genvar g = 0; g < N; g++) begin : g_word
    assign mem[g] = program_word(g);
  end

  assign word = mem[addr];

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW  = UA_W,
  parameter int OPW = OP_W
) (
  input  logic [AW-1:0]  upc,
  input  uinstr_t        word,
  input  logic [OPW-1:0] opcode,
  input  logic           flag_n,
  input  logic           flag_z,
  input  logic           mem_done,
  output logic [AW-1:0]  nxt,
  output logic           hold_o,
  output logic           end_o,
  output logic           branch_o,
  output logic           dispatch_o,
  output logic           step_o
);

  logic cond;

  always_comb begin
    cond       = word.test_z ? flag_z : flag_n;
    hold_o     = word.ctrl[B_WAIT_MEM] & ~mem_done;
    end_o      = word.ctrl[B_DONE] & ~hold_o;
    branch_o   = ~hold_o & ~end_o &
                 ((word.seq == SQ_JUMP) | ((word.seq == SQ_BRCOND) & cond));
    dispatch_o = ~hold_o & ~end_o & (word.seq == SQ_DISPATCH);
    step_o     = ~hold_o & ~end_o & ~branch_o & ~dispatch_o;

    if (hold_o)          nxt = upc;
    else if (end_o)      nxt = '0;
    else if (branch_o)   nxt = word.target;
    else if (dispatch_o) nxt = start_of(opcode);
    else                 nxt = succ(upc);
  end

endmodule

// File: rtl/useq_pc.sv
module useq_pc #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] upc
);

  always_ff @(posedge clk) begin
    if (!rst_n) upc <= '0;
    else        upc <= nxt;
  end

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW  = UA_W,
  parameter int OPW = OP_W,
  parameter int CW  = CTRL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] ir_opcode,
  input  logic           flag_n,
  input  logic           flag_z,
  input  logic           mem_done,
  output logic [CW-1:0]  ctrl_word,
  output logic           end_flag,
  output logic [AW-1:0]  micro_addr
);

  logic [AW-1:0] upc;
  logic [AW-1:0] nxt;
  logic [AW-1:0] br_target;
  uinstr_t       word;
  logic          ev_hold, ev_end, ev_branch, ev_dispatch, ev_step;

  useq_store #(.AW(AW)) u_store (
    .addr (upc),
    .word (word)
  );

  useq_next #(.AW(AW), .OPW(OPW)) u_next (
    .upc        (upc),
    .word       (word),
    .opcode     (ir_opcode),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .mem_done   (mem_done),
    .nxt        (nxt),
    .hold_o     (ev_hold),
    .end_o      (ev_end),
    .branch_o   (ev_branch),
    .dispatch_o (ev_dispatch),
    .step_o     (ev_step)
  );

  useq_pc #(.AW(AW)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt   (nxt),
    .upc   (upc)
  );

  assign br_target  = word.target;
  assign ctrl_word  = word.ctrl;
  assign end_flag   = word.ctrl[B_DONE];
  assign micro_addr = upc;

endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
  parameter int AW = 5,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] upc,
  input logic [CW-1:0] ctrl_word,
  input logic [AW-1:0] br_target,
  input logic          ev_hold,
  input logic          ev_end,
  input logic          ev_branch,
  input logic          ev_dispatch,
  input logic          ev_step
);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> ($stable(upc) && $stable(ctrl_word)));

  assert_end_to_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> (upc == '0));

  assert_step_increment_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> (upc == $past(upc) + AW'(1)));

  assert_branch_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_branch |=> (upc == $past(br_target)));

  assert_dispatch_leaves_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dispatch |=> (upc != '0));

endmodule

bind useq_top useq_checker #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/useq_top_test.sv
module useq_top_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ir_opcode;
  logic       flag_n, flag_z, mem_done;
  logic [15:0] ctrl_word;
  logic       end_flag;
  logic [4:0] micro_addr;

  int checks = 0;
  int fails  = 0;
  bit summary_done = 0;

  int    q_addr[$];
  bit    q_cchk[$];
  string q_tag[$];

  always #10 clk = ~clk;

  useq_top uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ir_opcode  (ir_opcode),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .mem_done   (mem_done),
    .ctrl_word  (ctrl_word),
    .end_flag   (end_flag),
    .micro_addr (micro_addr)
  );

  // expected control words for fetch and the add routine (R1, R2, R9)
  function automatic logic [15:0] exp_ctrl(input int a);
    case (a)
      0: return 16'h003F;
      1: return 16'h6440;
      2: return 16'h1800;
      3: return 16'h0206;
      4: return 16'h2480;
      5: return 16'h0830;
      6: return 16'h8140;
      default: return 16'h0000;
    endcase
  endfunction

  // words whose done bit is set (R8, R10)
  function automatic bit exp_end(input int a);
    return (a == 6) || (a == 9) || (a == 11) || (a == 13) || (a == 15) || (a == 18);
  endfunction

  task automatic report;
    if (!summary_done) begin
      summary_done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // driver: one cycle, with the address the design must show during it
  task automatic step(input int a, input bit md, input string tag);
    mem_done = md;
    q_addr.push_back(a);
    q_cchk.push_back(a <= 6);
    q_tag.push_back(tag);
    @(posedge clk);
    #3;
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_addr.size() > 0) begin
      int    a;
      bit    cc;
      string t;
      a  = q_addr.pop_front();
      cc = q_cchk.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (int'(micro_addr) != a) begin
        fails++;
        $display("FAIL %s: micro_addr actual %0d expected %0d", t, micro_addr, a);
      end else if (end_flag != exp_end(a)) begin
        fails++;
        $display("FAIL %s: end_flag at %0d actual %0b expected %0b", t, a, end_flag, exp_end(a));
      end else if (cc && ctrl_word != exp_ctrl(a)) begin
        fails++;
        $display("FAIL %s: ctrl_word at %0d actual %h expected %h", t, a, ctrl_word, exp_ctrl(a));
      end
    end
  end

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    report();
  end

  initial begin
    rst_n = 0; ir_opcode = 0; flag_n = 0; flag_z = 0; mem_done = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (micro_addr != 0 || ctrl_word != 16'h003F) begin
      fails++;
      $display("FAIL R1: in reset actual %0d/%h expected 0/003f", micro_addr, ctrl_word);
    end
    @(posedge clk); #3;
    rst_n = 1;

    // add routine, no memory stall (R1 R2 R3 R4 R9 R8)
    ir_opcode = 2'd0;
    step(0, 1, "R1"); step(1, 1, "R2"); step(2, 1, "R2"); step(3, 1, "R3");
    step(4, 1, "R4"); step(5, 1, "R9"); step(6, 1, "R9");
    // back to fetch, add again with stalls (R8 R7)
    step(0, 1, "R8"); step(1, 0, "R7"); step(1, 0, "R7"); step(1, 1, "R7");
    step(2, 1, "R2"); step(3, 0, "R7"); step(4, 0, "R7"); step(4, 0, "R7");
    step(4, 1, "R7"); step(5, 1, "R9"); step(6, 1, "R9");

    // N-test routine taken (R5)
    ir_opcode = 2'd1; flag_n = 1; flag_z = 0;
    step(0, 1, "R8"); step(1, 1, "R2"); step(2, 1, "R3"); step(8, 1, "R3");
    step(10, 1, "R5"); step(11, 1, "R5");
    // not taken (R5)
    flag_n = 0; flag_z = 1;
    step(0, 1, "R8"); step(1, 1, "R2"); step(2, 1, "R3"); step(8, 1, "R5");
    step(9, 1, "R5");

    // Z-test routine taken (R5)
    ir_opcode = 2'd2; flag_n = 0; flag_z = 1;
    step(0, 1, "R8"); step(1, 1, "R2"); step(2, 1, "R3"); step(12, 1, "R3");
    step(14, 1, "R5"); step(15, 1, "R5");
    // N set, Z clear: falls through (R10)
    flag_n = 1; flag_z = 0;
    step(0, 1, "R8"); step(1, 1, "R2"); step(2, 1, "R3"); step(12, 1, "R10");
    step(13, 1, "R10");

    // unconditional jump skips word 17 (R6)
    ir_opcode = 2'd3; flag_n = 0;
    step(0, 1, "R8"); step(1, 1, "R2"); step(2, 1, "R3"); step(16, 1, "R3");
    step(18, 1, "R6");
    step(0, 1, "R8");

    wait (q_addr.size() == 0);
    @(negedge clk); #1;
    report();
  end

endmodule